// File: doc/BRIEF.md
# Periodic Battery Test Sequencer

This block decides when the backup battery is put under load for a check, times each check, and keeps the result. A check starts when the battery-monitor enable goes from off to on, when main power comes up, or when the hour rolls over. It starts only while the monitor is enabled and the timekeeping oscillator is running. During a check the block drives a load-enable to the external load switch. It also passes a two-bit trip-threshold code to the external comparator. The comparator verdict is used only in the later part of the loaded window.

A failed check sets a sticky battery-alarm flag. The block also keeps sticky clock-alarm and watchdog-alarm flags, which it sets from event strobes. A single status-register write strobe clears all three flags at once. A battery-attach strobe also clears them. The enabled flags are combined into an active-low alarm output. The watchdog alarm can be steered either onto that combined output or onto its own active-low output.

A check lasts two phases of `PHASE_TICKS` one-second ticks each. With the default value of 1 this is a one-second settle phase followed by a one-second sample phase.

Top module: `batt_test_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle after that edge: `load_en`=0, all three flags are 0, `alarm_n`=1 and `wdog_n`=1.
- R2: A check starts, with `load_en` going to 1 after the edge, when at that edge `mon_en`=1 and `osc_run`=1 and one of these holds: `mon_en` was 0 at the previous edge, `pwr_up`=1, or `hour_roll`=1. With `osc_run`=0 or `mon_en`=0 no check starts.
- R3: Once started, `load_en` stays 1 through a settle phase and then a sample phase. Each phase ends at the edge that takes its `PHASE_TICKS`-th `sec_tick`. `load_en` is 0 after the edge that ends the sample phase.
- R4: `batt_alarm` is set only by `cmp_low`=1 (1 means battery below threshold) at an edge during the sample phase. `cmp_low` during the settle phase has no effect.
- R5: `batt_alarm` is sticky and a later passing check leaves it set. It clears only on `stat_wr` or `bat_attach`. A clear wins over a set at the same edge.
- R6: `trip_code` equals `trip_sel`: 00 selects 1.75 V, 01 selects 2.00 V, 10 selects 2.25 V and 11 selects 2.50 V nominal.
- R7: A trigger that arrives while a check is running is ignored, and the running check ends on its normal schedule.
- R8: If `mon_en` or `osc_run` is 0 at an edge during a check, the check is aborted: `load_en` is 0 after that edge and no flag is set at that edge.
- R9: `clk_match`=1 together with `clk_alm_en`=1 sets `clk_alarm`. `wd_expire`=1 together with `wd_en`=1 sets `wd_alarm`. Both flags are sticky. `stat_wr` or `bat_attach` clears `batt_alarm`, `clk_alarm` and `wd_alarm` together.
- R10: `alarm_n` is 0 exactly when any of these holds: `batt_alarm` and `mon_en`, `clk_alarm` and `clk_alm_en`, or `wd_alarm` and `wd_en` and `wd_route`=1. `wdog_n` is 0 exactly when `wd_alarm` and `wd_en` and `wd_route`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| hour_roll | input | 1 | Strobe when minutes and seconds both roll over to zero |
| pwr_up | input | 1 | Strobe when main power has come up |
| mon_en | input | 1 | Battery monitor enable |
| osc_run | input | 1 | Timekeeping oscillator running |
| trip_sel | input | 2 | Trip-threshold selection |
| cmp_low | input | 1 | Comparator verdict, 1 = battery below threshold |
| clk_match | input | 1 | Clock alarm match event |
| clk_alm_en | input | 1 | Clock alarm enable |
| wd_expire | input | 1 | Watchdog expiry event |
| wd_en | input | 1 | Watchdog enable |
| wd_route | input | 1 | 1 = watchdog alarm on `alarm_n`, 0 = on `wdog_n` |
| stat_wr | input | 1 | Status-register write strobe, clears all flags |
| bat_attach | input | 1 | Battery-attach strobe, clears all flags |
| load_en | output | 1 | Battery test load enable |
| trip_code | output | 2 | Threshold code sent to the comparator |
| batt_alarm | output | 1 | Sticky battery-alarm flag |
| clk_alarm | output | 1 | Sticky clock-alarm flag |
| wd_alarm | output | 1 | Sticky watchdog-alarm flag |
| alarm_n | output | 1 | Combined active-low alarm |
| wdog_n | output | 1 | Separate active-low watchdog alarm |

## Verification
Directed sequences hold `cmp_low` high through the settle phase and then pulse it in the sample phase, which separates a design that samples in the right window from one that samples during the whole load. A failing check followed by a passing one shows whether the flag is sticky. An hour strobe during a running check shows whether a retrigger would restart the timing and push `load_en` past its expected end. Dropping the oscillator in mid-check and sweeping the routing and enable bits cover aborts and every alarm output combination. Several thousand cycles of random strobes, with `PHASE_TICKS`=2, are then compared every cycle against a reference model kept in the bench.

// File: rtl/bts_pkg.sv
// Shared types for the battery test sequencer.
// Assumes: flag vector bit order batt, clock, watchdog.
package bts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SAMPLE = 2'd2
    } bts_state_e;

    localparam int FLAG_W   = 3;
    localparam int FLAG_BAT = 0;
    localparam int FLAG_CLK = 1;
    localparam int FLAG_WD  = 2;
endpackage

// File: rtl/bts_trigger.sv
// Trigger detector: produces a one-cycle start request on monitor
// enable rising, power-up or hour rollover.
// Assumes: strobes are single-cycle and synchronous to clk; a busy
// sequencer swallows requests (R7).
module bts_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic run_ok,
    input  logic pwr_up,
    input  logic hour_roll,
    input  logic busy,
    output logic start
);
    logic mon_q;

    // Remember the previous enable level for rising-edge detection (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) mon_q <= 1'b0;
        else        mon_q <= mon_en;
    end

    // Start only when allowed and not already testing (R2, R7).
    always_comb begin
        start = run_ok && !busy && ((mon_en && !mon_q) || pwr_up || hour_roll);
    end
endmodule

// File: rtl/bts_sequencer.sv
// Test window sequencer: settle phase, then sample phase, each
// PHASE_TICKS second ticks long; load applied throughout.
// Assumes: run_ok low aborts immediately (R8).
module bts_sequencer #(
    parameter int PHASE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run_ok,
    input  logic sec_tick,
    output logic load_en,
    output logic in_sample,
    output logic busy
);
    import bts_pkg::*;

    localparam int CW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;

    bts_state_e     state;
    logic [CW-1:0]  tick_cnt;
    logic           last_tick;

    // Phase end detection.
    always_comb begin
        last_tick = (tick_cnt == CW'(PHASE_TICKS - 1));
    end

    // Phase state machine with abort (R3, R8).
    always_ff @(posedge clk) begin
        if (!rst_n || !run_ok) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SETTLE;
                        tick_cnt <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (sec_tick) begin
                        if (last_tick) begin
                            state    <= ST_SAMPLE;
                            tick_cnt <= '0;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (sec_tick) begin
                        if (last_tick) begin
                            state    <= ST_IDLE;
                            tick_cnt <= '0;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state    <= ST_IDLE;
                    tick_cnt <= '0;
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        load_en   = (state != ST_IDLE);
        in_sample = (state == ST_SAMPLE);
        busy      = load_en;
    end

    // R8: load is only applied after an edge where running was allowed.
    a_r8_load_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> $past(run_ok));

    // R3: the sample phase is always entered from a loaded state.
    a_r3_sample_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sample) |-> $past(load_en));
endmodule

// File: rtl/bts_flags.sv
// Sticky alarm flags and active-low alarm output combining.
// Assumes: clear strobes win over set events at the same edge.
module bts_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sample,
    input  logic run_ok,
    input  logic cmp_low,
    input  logic clk_match,
    input  logic clk_alm_en,
    input  logic wd_expire,
    input  logic wd_en,
    input  logic mon_en,
    input  logic wd_route,
    input  logic stat_wr,
    input  logic bat_attach,
    output logic batt_alarm,
    output logic clk_alarm,
    output logic wd_alarm,
    output logic alarm_n,
    output logic wdog_n
);
    import bts_pkg::*;

    logic [FLAG_W-1:0] set_ev;
    logic [FLAG_W-1:0] flags;
    logic              clr;

    // Set events per flag (R4, R9).
    always_comb begin
        set_ev[FLAG_BAT] = in_sample && run_ok && cmp_low;
        set_ev[FLAG_CLK] = clk_match && clk_alm_en;
        set_ev[FLAG_WD]  = wd_expire && wd_en;
        clr              = stat_wr || bat_attach;
    end

    // One sticky cell per flag (R5, R9).
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || clr) flags[i] <= 1'b0;
            else if (set_ev[i]) flags[i] <= 1'b1;
        end
    end

    // Alarm routing to the two active-low outputs (R10).
    always_comb begin
        batt_alarm = flags[FLAG_BAT];
        clk_alarm  = flags[FLAG_CLK];
        wd_alarm   = flags[FLAG_WD];
        alarm_n    = !((batt_alarm && mon_en) || (clk_alarm && clk_alm_en) ||
                       (wd_alarm && wd_en && wd_route));
        wdog_n     = !(wd_alarm && wd_en && !wd_route);
    end

    // R5: battery flag holds unless cleared.
    a_r5_batt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_alarm && !stat_wr && !bat_attach) |=> batt_alarm);

    // R9: a status write clears every flag.
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (!batt_alarm && !clk_alarm && !wd_alarm));

    // R4: battery flag rises only after a sample-phase edge.
    a_r4_set_in_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_alarm) |-> $past(in_sample));
endmodule

// File: rtl/batt_test_seq.sv
// Periodic battery test sequencer top: triggers, times and records
// backup battery load tests and combines the alarm flags.
// Assumes: all inputs synchronous to clk; comparator and load switch external.
module batt_test_seq #(
    parameter int PHASE_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       hour_roll,
    input  logic       pwr_up,
    input  logic       mon_en,
    input  logic       osc_run,
    input  logic [1:0] trip_sel,
    input  logic       cmp_low,
    input  logic       clk_match,
    input  logic       clk_alm_en,
    input  logic       wd_expire,
    input  logic       wd_en,
    input  logic       wd_route,
    input  logic       stat_wr,
    input  logic       bat_attach,
    output logic       load_en,
    output logic [1:0] trip_code,
    output logic       batt_alarm,
    output logic       clk_alarm,
    output logic       wd_alarm,
    output logic       alarm_n,
    output logic       wdog_n
);
    logic run_ok;
    logic start;
    logic busy;
    logic in_sample;

    // Testing permitted only with monitor enabled and oscillator running.
    always_comb begin
        run_ok    = mon_en && osc_run;
        trip_code = trip_sel;
    end

    bts_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .run_ok(run_ok),
        .pwr_up(pwr_up), .hour_roll(hour_roll), .busy(busy), .start(start)
    );

    bts_sequencer #(.PHASE_TICKS(PHASE_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .run_ok(run_ok),
        .sec_tick(sec_tick), .load_en(load_en), .in_sample(in_sample),
        .busy(busy)
    );

    bts_flags u_flags (
        .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .run_ok(run_ok),
        .cmp_low(cmp_low), .clk_match(clk_match), .clk_alm_en(clk_alm_en),
        .wd_expire(wd_expire), .wd_en(wd_en), .mon_en(mon_en),
        .wd_route(wd_route), .stat_wr(stat_wr), .bat_attach(bat_attach),
        .batt_alarm(batt_alarm), .clk_alarm(clk_alarm), .wd_alarm(wd_alarm),
        .alarm_n(alarm_n), .wdog_n(wdog_n)
    );
endmodule

// File: tb/batt_test_seq_tb.sv
module batt_test_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 2;

    logic clk = 1'b0;
    logic rst_n, sec_tick, hour_roll, pwr_up, mon_en, osc_run, cmp_low;
    logic clk_match, clk_alm_en, wd_expire, wd_en, wd_route, stat_wr, bat_attach;
    logic [1:0] trip_sel;
    logic load_en, batt_alarm, clk_alarm, wd_alarm, alarm_n, wdog_n;
    logic [1:0] trip_code;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // Reference model state
    int  m_state = 0;
    int  m_cnt = 0;
    bit  m_monq = 0, m_bat = 0, m_clk = 0, m_wd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    batt_test_seq #(.PHASE_TICKS(PH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hour_roll(hour_roll),
        .pwr_up(pwr_up), .mon_en(mon_en), .osc_run(osc_run), .trip_sel(trip_sel),
        .cmp_low(cmp_low), .clk_match(clk_match), .clk_alm_en(clk_alm_en),
        .wd_expire(wd_expire), .wd_en(wd_en), .wd_route(wd_route),
        .stat_wr(stat_wr), .bat_attach(bat_attach), .load_en(load_en),
        .trip_code(trip_code), .batt_alarm(batt_alarm), .clk_alarm(clk_alarm),
        .wd_alarm(wd_alarm), .alarm_n(alarm_n), .wdog_n(wdog_n)
    );

    function automatic bit exp_alarm_n();
        return !((m_bat && mon_en) || (m_clk && clk_alm_en) || (m_wd && wd_en && wd_route));
    endfunction

    function automatic bit exp_wdog_n();
        return !(m_wd && wd_en && !wd_route);
    endfunction

    // Model update from requirements R1-R10 behaviour
    always @(posedge clk) begin
        bit en, trig, setb, clr;
        en   = mon_en && osc_run;
        trig = en && ((mon_en && !m_monq) || pwr_up || hour_roll);
        setb = (m_state == 2) && en && cmp_low;
        clr  = stat_wr || bat_attach;
        if (!rst_n) begin
            m_state <= 0; m_cnt <= 0; m_monq <= 0; m_bat <= 0; m_clk <= 0; m_wd <= 0;
        end else begin
            m_monq <= mon_en;
            if (!en) begin
                m_state <= 0; m_cnt <= 0;
            end else if (m_state == 0) begin
                if (trig) begin m_state <= 1; m_cnt <= 0; end
            end else if (sec_tick) begin
                if (m_cnt == PH - 1) begin
                    m_state <= (m_state == 1) ? 2 : 0; m_cnt <= 0;
                end else m_cnt <= m_cnt + 1;
            end
            if (clr) begin
                m_bat <= 0; m_clk <= 0; m_wd <= 0;
            end else begin
                if (setb) m_bat <= 1;
                if (clk_match && clk_alm_en) m_clk <= 1;
                if (wd_expire && wd_en) m_wd <= 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R3 load_en vs model", load_en, m_state != 0);
        chk("R4 batt_alarm vs model", batt_alarm, m_bat);
        chk("R9 clk_alarm vs model", clk_alarm, m_clk);
        chk("R9 wd_alarm vs model", wd_alarm, m_wd);
        chk("R6 trip_code", trip_code, trip_sel);
        chk("R10 alarm_n", alarm_n, exp_alarm_n());
        chk("R10 wdog_n", wdog_n, exp_wdog_n());
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic tick();
        sec_tick = 1; cyc(); sec_tick = 0; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BA7_7E57));
        rst_n = 0; sec_tick = 0; hour_roll = 0; pwr_up = 0; mon_en = 0; osc_run = 0;
        cmp_low = 0; clk_match = 0; clk_alm_en = 0; wd_expire = 0; wd_en = 0;
        wd_route = 0; stat_wr = 0; bat_attach = 0; trip_sel = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 load_en", load_en, 0);
        chk("R1 flags", {batt_alarm, clk_alarm, wd_alarm}, 0);
        chk("R1 alarm_n", alarm_n, 1);
        chk("R1 wdog_n", wdog_n, 1);
        rst_n = 1; osc_run = 1;
        cyc();
        // R2 start on enable rising
        mon_en = 1; cyc();
        chk("R2 start on enable", load_en, 1);
        // R4 settle-phase comparator ignored
        cmp_low = 1; tick();
        sec_tick = 1; cyc();
        sec_tick = 0; cmp_low = 0; cyc();
        chk("R4 settle ignored", batt_alarm, 0);
        chk("R3 load in sample", load_en, 1);
        // R7 retrigger during test ignored
        hour_roll = 1; cyc(); hour_roll = 0;
        cmp_low = 1; cyc(); cmp_low = 0;
        chk("R4 sample sets flag", batt_alarm, 1);
        tick(); tick();
        chk("R7 retrigger ignored, test ends", load_en, 0);
        // R5 sticky across a passing test
        hour_roll = 1; cyc(); hour_roll = 0;
        chk("R2 hour trigger", load_en, 1);
        repeat (4) tick();
        chk("R3 load off after window", load_en, 0);
        chk("R5 sticky after pass", batt_alarm, 1);
        bat_attach = 1; cyc(); bat_attach = 0;
        chk("R5 attach clear", batt_alarm, 0);
        // R8 abort
        pwr_up = 1; cyc(); pwr_up = 0;
        chk("R2 power-up trigger", load_en, 1);
        osc_run = 0; cyc();
        chk("R8 abort on oscillator stop", load_en, 0);
        pwr_up = 1; cyc(); pwr_up = 0;
        chk("R2 no start without oscillator", load_en, 0);
        osc_run = 1; cyc();
        // R9 / R10 flags and routing
        clk_alm_en = 1; clk_match = 1; cyc(); clk_match = 0;
        wd_en = 1; wd_expire = 1; cyc(); wd_expire = 0;
        chk("R9 clk set", clk_alarm, 1);
        chk("R9 wd set", wd_alarm, 1);
        chk("R10 wdog_n routed separate", wdog_n, 0);
        chk("R10 alarm_n clock", alarm_n, 0);
        clk_alm_en = 0; cyc();
        chk("R10 alarm_n no enabled source", alarm_n, 1);
        wd_route = 1; cyc();
        chk("R10 alarm_n watchdog routed", alarm_n, 0);
        chk("R10 wdog_n idle when routed", wdog_n, 1);
        stat_wr = 1; cyc(); stat_wr = 0;
        chk("R9 clear all", {batt_alarm, clk_alarm, wd_alarm}, 0);
        // R6 trip code map
        for (int i = 0; i < 4; i++) begin
            trip_sel = 2'(i); cyc();
            chk("R6 trip code", trip_code, i);
        end
        // Random phase
        for (int n = 0; n < 6000; n++) begin
            sec_tick   = ($urandom % 4) == 0;
            hour_roll  = ($urandom % 40) == 0;
            pwr_up     = ($urandom % 60) == 0;
            if (($urandom % 50) == 0) mon_en = ~mon_en;
            osc_run    = ($urandom % 100) != 0;
            cmp_low    = ($urandom % 3) == 0;
            clk_match  = ($urandom % 30) == 0;
            wd_expire  = ($urandom % 30) == 0;
            clk_alm_en = ($urandom % 4) != 0;
            wd_en      = ($urandom % 4) != 0;
            wd_route   = $urandom % 2;
            stat_wr    = ($urandom % 40) == 0;
            bat_attach = ($urandom % 200) == 0;
            trip_sel   = 2'($urandom % 4);
            rst_n      = ($urandom % 700) != 0;
            cyc();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule